// File: doc/BRIEF.md
# Biphasic Stimulation Channel Sequencer

This block is the digital sequencer of a stimulator module with four parallel current channels, each able to drive one of four electrode sites. A decoded stimulation instruction names a channel, a site, an amplitude code with a current range, a phase length and an interphase gap. For each accepted instruction the addressed channel runs one charge-balanced pulse: a cathodic phase, an optional gap, an anodic phase of the same length, and a fixed shorting window that bleeds residual charge off the electrode. During the pulse it drives the per-site switch enables and presents the amplitude and range codes to the channel's current DAC.

Pulses are never timed internally; an instruction or a trigger starts every one of them. In immediate mode a channel fires as soon as its instruction is taken. In deferred mode the channel stores the parameters and waits, and a broadcast trigger fires all waiting channels together. A global inhibit cuts every switch at once and drops all channels back to idle. A separate combinational decoder routes one site of one channel to the voltage-monitor bus.

Top module: `stim_seq_top`

## Requirements
- R1: Four channels run independently; the enable bit for channel c, site s sits at index c*4+s of each enable vector, and at most one site of a channel is enabled at a time.
- R2: In immediate mode (sync_mode=0) an instruction sampled at clock edge k to an idle channel shows its cathodic phase in the cycle after edge k.
- R3: A pulse lasts max(1,P) cycles cathodic, then G cycles of gap (no gap when G=0), then max(1,P) cycles anodic, then SHORT_CYC (default 4) cycles of shorting, then the channel is idle; P and G are 8-bit cycle counts.
- R4: Switch patterns: cathodic drives en_dac and en_high on the active site, anodic drives en_dac and en_low, shorting drives en_ref only, gap and idle drive nothing; en_high and en_low are never both set on one site.
- R5: amp_code and range_code of a channel carry the stored values during the cathodic and anodic phases and are zero in every other phase.
- R6: In deferred mode (sync_mode=1) an accepted instruction only arms the channel (busy high, no enables); a trigger fires every armed channel in the following cycle; an instruction arriving with the trigger arms its channel without firing it.
- R7: busy of a channel is high from acceptance until its shorting window ends; an instruction to a busy or armed channel is ignored and leaves no trace on the outputs.
- R8: While inhibit is high every enable and code output is zero in the same cycle; one edge later every channel is idle and unarmed; instructions and triggers seen with inhibit are dropped.
- R9: With mon_en high, mon_chan_sel and mon_site_sel are one-hot at the indices mon_chan and mon_site; with mon_en low both are zero.
- R10: A trigger while no channel is armed changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stimulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit | input | 1 | Global stop: gates all enables, returns channels to idle |
| sync_mode | input | 1 | 0 fire on receipt, 1 arm and wait for trigger |
| cmd_valid | input | 1 | Instruction strobe, one cycle |
| cmd_chan | input | 2 | Target channel |
| cmd_site | input | 2 | Site within the channel |
| cmd_amp | input | 5 | DAC amplitude code |
| cmd_range | input | 2 | DAC current range |
| cmd_phase | input | 8 | Phase length in cycles |
| cmd_gap | input | 8 | Interphase gap in cycles |
| trigger | input | 1 | Broadcast fire for armed channels |
| mon_en | input | 1 | Monitor routing enable |
| mon_chan | input | 2 | Channel routed to monitor bus |
| mon_site | input | 2 | Site routed to monitor bus |
| en_high | output | 16 | Per-site high-rail switch |
| en_dac | output | 16 | Per-site DAC path switch |
| en_ref | output | 16 | Per-site reference (shorting) switch |
| en_low | output | 16 | Per-site low-rail switch |
| amp_code | output | 20 | Amplitude code, 5 bits per channel |
| range_code | output | 8 | Range code, 2 bits per channel |
| busy | output | 4 | Channel armed or mid-pulse |
| mon_chan_sel | output | 4 | One-hot monitor channel select |
| mon_site_sel | output | 4 | One-hot monitor site select |

## Verification
Two functions can meet in one cycle: a trigger that fires the armed channels, and a new deferred-mode instruction to another idle channel, which must arm but not fire; the bench issues both in the same cycle and then expects pulse events only from the previously armed channels until a second trigger releases the newcomer. Inhibit can likewise coincide with an instruction; the bench raises both together mid-pulse, checks that the enables drop within that cycle, and expects no pulse from the dropped instruction. Every enable transition per channel is compared in time against a queue of events predicted from the phase arithmetic.

// File: rtl/stim_pkg.sv
package stim_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARMED,
    PH_CATH,
    PH_GAP,
    PH_ANOD,
    PH_SHORT
  } phase_e;

  typedef struct packed {
    logic hi;
    logic dac;
    logic rf;
    logic lo;
  } sw_t;

  // Switch pattern for each phase of a pulse.
  function automatic sw_t sw_for(input phase_e p);
    sw_t s;
    s = '0;
    case (p)
      PH_CATH:  begin s.dac = 1'b1; s.hi = 1'b1; end
      PH_ANOD:  begin s.dac = 1'b1; s.lo = 1'b1; end
      PH_SHORT: s.rf = 1'b1;
      default:  s = '0;
    endcase
    return s;
  endfunction

  // Phases in which the current source is driven.
  function automatic logic is_drive(input phase_e p);
    return (p == PH_CATH) || (p == PH_ANOD);
  endfunction

endpackage

// File: rtl/stim_chan_ctrl.sv
module stim_chan_ctrl
  import stim_pkg::*;
#(
  parameter int SITES     = 4,
  parameter int AMP_W     = 5,
  parameter int RNG_W     = 2,
  parameter int DUR_W     = 8,
  parameter int SHORT_CYC = 4,
  localparam int SITE_W   = $clog2(SITES),
  localparam int SHORT_W  = $clog2(SHORT_CYC + 1),
  localparam int CNT_W    = (DUR_W > SHORT_W) ? DUR_W : SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit,
  input  logic              load,
  input  logic              sync_mode,
  input  logic              trigger,
  input  logic [SITE_W-1:0] cmd_site,
  input  logic [AMP_W-1:0]  cmd_amp,
  input  logic [RNG_W-1:0]  cmd_range,
  input  logic [DUR_W-1:0]  cmd_phase,
  input  logic [DUR_W-1:0]  cmd_gap,
  output phase_e            phase_o,
  output logic [SITE_W-1:0] site_o,
  output logic [AMP_W-1:0]  amp_o,
  output logic [RNG_W-1:0]  rng_o,
  output logic              busy_o,
  output logic              armed_o,
  output logic              fire_o
);

  // Counter preload for a phase of length max(1,f): the phase ends on cnt==0.
  function automatic logic [CNT_W-1:0] phase_preload(input logic [DUR_W-1:0] f);
    logic [CNT_W-1:0] w;
    w = CNT_W'(f);
    return (w == '0) ? '0 : w - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] gap_preload(input logic [DUR_W-1:0] f);
    return CNT_W'(f) - CNT_W'(1);
  endfunction

  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SITE_W-1:0] site_q;
  logic [AMP_W-1:0]  amp_q;
  logic [RNG_W-1:0]  rng_q;
  logic [DUR_W-1:0]  plen_q;
  logic [DUR_W-1:0]  gap_q;

  logic accept;
  logic cnt_done;

  assign accept   = load && (ph_q == PH_IDLE) && !inhibit;
  assign cnt_done = (cnt_q == '0);
  assign fire_o   = !inhibit && ((accept && !sync_mode) ||
                                 ((ph_q == PH_ARMED) && trigger));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      site_q <= '0;
      amp_q  <= '0;
      rng_q  <= '0;
      plen_q <= '0;
      gap_q  <= '0;
    end else if (inhibit) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            site_q <= cmd_site;
            amp_q  <= cmd_amp;
            rng_q  <= cmd_range;
            plen_q <= cmd_phase;
            gap_q  <= cmd_gap;
            if (sync_mode) begin
              ph_q <= PH_ARMED;
            end else begin
              ph_q  <= PH_CATH;
              cnt_q <= phase_preload(cmd_phase);
            end
          end
        end
        PH_ARMED: begin
          if (trigger) begin
            ph_q  <= PH_CATH;
            cnt_q <= phase_preload(plen_q);
          end
        end
        PH_CATH: begin
          if (!cnt_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (gap_q != '0) begin
            ph_q  <= PH_GAP;
            cnt_q <= gap_preload(gap_q);
          end else begin
            ph_q  <= PH_ANOD;
            cnt_q <= phase_preload(plen_q);
          end
        end
        PH_GAP: begin
          if (!cnt_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            ph_q  <= PH_ANOD;
            cnt_q <= phase_preload(plen_q);
          end
        end
        PH_ANOD: begin
          if (!cnt_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            ph_q  <= PH_SHORT;
            cnt_q <= SHORT_LOAD;
          end
        end
        PH_SHORT: begin
          if (!cnt_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            ph_q <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = ph_q;
  assign site_o  = site_q;
  assign amp_o   = amp_q;
  assign rng_o   = rng_q;
  assign busy_o  = (ph_q != PH_IDLE);
  assign armed_o = (ph_q == PH_ARMED);

endmodule

// File: rtl/stim_sw_decode.sv
module stim_sw_decode
  import stim_pkg::*;
#(
  parameter int SITES   = 4,
  localparam int SITE_W = $clog2(SITES)
) (
  input  phase_e            phase,
  input  logic [SITE_W-1:0] site,
  input  logic              inhibit,
  output logic [SITES-1:0]  hi,
  output logic [SITES-1:0]  dac,
  output logic [SITES-1:0]  rf,
  output logic [SITES-1:0]  lo
);

  sw_t pat;

  always_comb begin
    pat = inhibit ? '0 : sw_for(phase);
  end

  for (genvar j = 0; j < SITES; j++) begin : g_site
    logic sel;
    assign sel    = (site == SITE_W'(j));
    assign hi[j]  = pat.hi  && sel;
    assign dac[j] = pat.dac && sel;
    assign rf[j]  = pat.rf  && sel;
    assign lo[j]  = pat.lo  && sel;
  end

endmodule

// File: rtl/stim_mon_sel.sv
module stim_mon_sel #(
  parameter int N_CH    = 4,
  parameter int SITES   = 4,
  localparam int CH_W   = $clog2(N_CH),
  localparam int SITE_W = $clog2(SITES)
) (
  input  logic              mon_en,
  input  logic [CH_W-1:0]   mon_chan,
  input  logic [SITE_W-1:0] mon_site,
  output logic [N_CH-1:0]   chan_sel,
  output logic [SITES-1:0]  site_sel
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign chan_sel[c] = mon_en && (mon_chan == CH_W'(c));
  end

  for (genvar s = 0; s < SITES; s++) begin : g_st
    assign site_sel[s] = mon_en && (mon_site == SITE_W'(s));
  end

endmodule

// File: rtl/stim_seq_top.sv
module stim_seq_top
  import stim_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int SITES     = 4,
  parameter int AMP_W     = 5,
  parameter int RNG_W     = 2,
  parameter int DUR_W     = 8,
  parameter int SHORT_CYC = 4,
  localparam int CH_W     = $clog2(N_CH),
  localparam int SITE_W   = $clog2(SITES),
  localparam int EN_W     = N_CH * SITES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inhibit,
  input  logic                   sync_mode,
  input  logic                   cmd_valid,
  input  logic [CH_W-1:0]        cmd_chan,
  input  logic [SITE_W-1:0]      cmd_site,
  input  logic [AMP_W-1:0]       cmd_amp,
  input  logic [RNG_W-1:0]       cmd_range,
  input  logic [DUR_W-1:0]       cmd_phase,
  input  logic [DUR_W-1:0]       cmd_gap,
  input  logic                   trigger,
  input  logic                   mon_en,
  input  logic [CH_W-1:0]        mon_chan,
  input  logic [SITE_W-1:0]      mon_site,
  output logic [EN_W-1:0]        en_high,
  output logic [EN_W-1:0]        en_dac,
  output logic [EN_W-1:0]        en_ref,
  output logic [EN_W-1:0]        en_low,
  output logic [N_CH*AMP_W-1:0]  amp_code,
  output logic [N_CH*RNG_W-1:0]  range_code,
  output logic [N_CH-1:0]        busy,
  output logic [N_CH-1:0]        mon_chan_sel,
  output logic [SITES-1:0]       mon_site_sel
);

  phase_e            ph_w   [N_CH];
  logic [SITE_W-1:0] site_w [N_CH];
  logic [AMP_W-1:0]  amp_w  [N_CH];
  logic [RNG_W-1:0]  rng_w  [N_CH];
  logic [N_CH-1:0]   armed_w;
  logic [N_CH-1:0]   fire_w;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    logic load_c;
    logic drive_c;

    assign load_c = cmd_valid && (cmd_chan == CH_W'(c));

    stim_chan_ctrl #(
      .SITES(SITES), .AMP_W(AMP_W), .RNG_W(RNG_W),
      .DUR_W(DUR_W), .SHORT_CYC(SHORT_CYC)
    ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .inhibit   (inhibit),
      .load      (load_c),
      .sync_mode (sync_mode),
      .trigger   (trigger),
      .cmd_site  (cmd_site),
      .cmd_amp   (cmd_amp),
      .cmd_range (cmd_range),
      .cmd_phase (cmd_phase),
      .cmd_gap   (cmd_gap),
      .phase_o   (ph_w[c]),
      .site_o    (site_w[c]),
      .amp_o     (amp_w[c]),
      .rng_o     (rng_w[c]),
      .busy_o    (busy[c]),
      .armed_o   (armed_w[c]),
      .fire_o    (fire_w[c])
    );

    stim_sw_decode #(.SITES(SITES)) u_sw (
      .phase   (ph_w[c]),
      .site    (site_w[c]),
      .inhibit (inhibit),
      .hi      (en_high[c*SITES +: SITES]),
      .dac     (en_dac[c*SITES +: SITES]),
      .rf      (en_ref[c*SITES +: SITES]),
      .lo      (en_low[c*SITES +: SITES])
    );

    assign drive_c = is_drive(ph_w[c]) && !inhibit;
    assign amp_code[c*AMP_W +: AMP_W]   = drive_c ? amp_w[c] : '0;
    assign range_code[c*RNG_W +: RNG_W] = drive_c ? rng_w[c] : '0;
  end

  stim_mon_sel #(.N_CH(N_CH), .SITES(SITES)) u_mon (
    .mon_en   (mon_en),
    .mon_chan (mon_chan),
    .mon_site (mon_site),
    .chan_sel (mon_chan_sel),
    .site_sel (mon_site_sel)
  );

endmodule

// File: rtl/stim_seq_checker.sv
module stim_seq_checker #(
  parameter int N_CH  = 4,
  parameter int SITES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  inhibit,
  input logic                  mon_en,
  input logic [N_CH*SITES-1:0] en_high,
  input logic [N_CH*SITES-1:0] en_dac,
  input logic [N_CH*SITES-1:0] en_ref,
  input logic [N_CH*SITES-1:0] en_low,
  input logic [N_CH-1:0]       busy,
  input logic [N_CH-1:0]       armed,
  input logic [N_CH-1:0]       fire,
  input logic [N_CH-1:0]       mon_chan_sel,
  input logic [SITES-1:0]      mon_site_sel
);

  // R4: a site never sees both rails at once.
  a_r4_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (en_high & en_low) == '0);

  // R8: inhibit drops every enable within its own cycle.
  always_comb begin
    if (rst_n === 1'b1 && inhibit === 1'b1) begin
      a_r8_gate_now: assert ((en_high | en_dac | en_ref | en_low) == '0);
    end
  end

  // R8: one edge after inhibit all channels are idle.
  a_r8_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (busy == '0));

  // R9: monitor routing is one-hot when enabled, silent otherwise.
  a_r9_mon_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> ($countones(mon_chan_sel) == 1 && $countones(mon_site_sel) == 1));
  a_r9_mon_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (mon_chan_sel == '0 && mon_site_sel == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    logic [SITES-1:0] any_c;
    logic [SITES-1:0] cath_c;
    assign any_c  = en_high[c*SITES +: SITES] | en_dac[c*SITES +: SITES] |
                    en_ref[c*SITES +: SITES]  | en_low[c*SITES +: SITES];
    assign cath_c = en_dac[c*SITES +: SITES] & en_high[c*SITES +: SITES];

    // R1: one site per channel at most.
    a_r1_one_site: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(any_c));

    // R6: an armed channel keeps its switches open.
    a_r6_armed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      armed[c] |-> (any_c == '0));

    // R2 / R6: a firing event yields a cathodic phase on the next cycle.
    a_r2_fire_cath: assert property (@(posedge clk) disable iff (!rst_n || inhibit)
      fire[c] |=> (cath_c != '0));

    // R7: busy only ends right after a shorting cycle, unless inhibited.
    a_r7_release_after_short: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy[c]) && !$past(inhibit)) |-> $past(|en_ref[c*SITES +: SITES]));
  end

endmodule

bind stim_seq_top stim_seq_checker #(.N_CH(N_CH), .SITES(SITES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .inhibit      (inhibit),
  .mon_en       (mon_en),
  .en_high      (en_high),
  .en_dac       (en_dac),
  .en_ref       (en_ref),
  .en_low       (en_low),
  .busy         (busy),
  .armed        (armed_w),
  .fire         (fire_w),
  .mon_chan_sel (mon_chan_sel),
  .mon_site_sel (mon_site_sel)
);

// File: tb/stim_seq_top_bench.sv
module stim_seq_top_bench;

  localparam int N_CH = 4, SITES = 4, AMP_W = 5, RNG_W = 2, DUR_W = 8, SHORT_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0, inhibit = 1'b0, sync_mode = 1'b0;
  logic cmd_valid = 1'b0, trigger = 1'b0, mon_en = 1'b0;
  logic [1:0] cmd_chan = '0, cmd_site = '0, cmd_range = '0, mon_chan = '0, mon_site = '0;
  logic [4:0] cmd_amp = '0;
  logic [7:0] cmd_phase = '0, cmd_gap = '0;

  logic [15:0] en_high, en_dac, en_ref, en_low;
  logic [19:0] amp_code;
  logic [7:0]  range_code;
  logic [3:0]  busy, mon_chan_sel, mon_site_sel;

  stim_seq_top u_stim_seq_top (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .sync_mode(sync_mode),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_site(cmd_site),
    .cmd_amp(cmd_amp), .cmd_range(cmd_range), .cmd_phase(cmd_phase),
    .cmd_gap(cmd_gap), .trigger(trigger), .mon_en(mon_en),
    .mon_chan(mon_chan), .mon_site(mon_site),
    .en_high(en_high), .en_dac(en_dac), .en_ref(en_ref), .en_low(en_low),
    .amp_code(amp_code), .range_code(range_code), .busy(busy),
    .mon_chan_sel(mon_chan_sel), .mon_site_sel(mon_site_sel)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;

  longint exp_q [N_CH][$];
  longint prev_obs [N_CH];
  int     end_cyc [N_CH];
  bit     armed_m [N_CH];
  int     a_site [N_CH], a_amp [N_CH], a_rng [N_CH], a_ph [N_CH], a_gp [N_CH];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Event word: cycle | site | phase code (1 cath, 3 anod, 4 short, 0 none) | range | amp
  function automatic longint mk(input int t, input int site, input int code,
                                input int rng, input int amp);
    return (longint'(t) << 20) | (longint'(site) << 16) | (longint'(code) << 12) |
           (longint'(rng) << 8) | longint'(amp);
  endfunction

  // R3: predicted event times of one pulse starting in cycle f.
  task automatic push_pulse(input int ch, input int f, input int site, input int amp,
                            input int rng, input int ph, input int gp);
    int pe;
    int t;
    pe = (ph == 0) ? 1 : ph;
    t  = f;
    exp_q[ch].push_back(mk(t, site, 1, rng, amp));
    t += pe;
    if (gp != 0) begin
      exp_q[ch].push_back(mk(t, 0, 0, 0, 0));
      t += gp;
    end
    exp_q[ch].push_back(mk(t, site, 3, rng, amp));
    t += pe;
    exp_q[ch].push_back(mk(t, site, 4, 0, 0));
    t += SHORT_CYC;
    exp_q[ch].push_back(mk(t, 0, 0, 0, 0));
    end_cyc[ch] = t;
  endtask

  // Monitor: pops one expected event per observed output change.
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      for (int c = 0; c < N_CH; c++) begin
        logic [3:0] h, d, r, l, any;
        int s, code;
        longint obs, e, act;
        string tag;
        h = en_high[c*4 +: 4]; d = en_dac[c*4 +: 4];
        r = en_ref[c*4 +: 4];  l = en_low[c*4 +: 4];
        any = h | d | r | l;
        s = 0;
        for (int j = 0; j < 4; j++) if (any[j]) s = j;
        if ((d & h) != 0) code = 1;
        else if ((d & l) != 0) code = 3;
        else if (r != 0) code = 4;
        else code = 0;
        obs = (longint'(range_code[c*2 +: 2]) << 8) | longint'(amp_code[c*5 +: 5]);
        if (code != 0) obs = obs | (longint'(s) << 16) | (longint'(code) << 12);
        if (obs != prev_obs[c]) begin
          act = (longint'(cyc) << 20) | obs;
          if (exp_q[c].size() == 0) begin
            check(1'b0, "R7 unexpected output change", act, 0);
          end else begin
            e = exp_q[c].pop_front();
            case (code)
              1:       tag = "R1 R2 R5 cathodic start";
              3:       tag = "R4 R5 anodic start";
              4:       tag = "R3 R4 shorting start";
              default: tag = "R3 phase end";
            endcase
            check(e == act, tag, act, e);
          end
          prev_obs[c] = obs;
        end
      end
    end
  end

  // One cycle of stimulus; the bench model decides acceptance on its own.
  task automatic step(input bit dc, input int ch, input int site, input int amp,
                      input int rng, input int ph, input int gp, input bit sm,
                      input bit trg, input bit inh);
    int k;
    bit acc;
    @(negedge clk);
    #1;
    k = cyc;
    cmd_valid = dc; cmd_chan = 2'(ch); cmd_site = 2'(site); cmd_amp = 5'(amp);
    cmd_range = 2'(rng); cmd_phase = 8'(ph); cmd_gap = 8'(gp);
    sync_mode = sm; trigger = trg; inhibit = inh;
    if (inh) begin
      for (int c = 0; c < N_CH; c++) begin
        exp_q[c].delete();
        armed_m[c] = 1'b0;
        if (prev_obs[c] != 0) exp_q[c].push_back(mk(k + 1, 0, 0, 0, 0));
        end_cyc[c] = k;
      end
      #1;
      check((en_high | en_dac | en_ref | en_low) == 0, "R8 enables cut in same cycle",
            longint'({en_high, en_dac, en_ref, en_low}), 0);
      check(amp_code == 0, "R8 amplitude cut in same cycle", amp_code, 0);
    end else begin
      acc = dc && !armed_m[ch] && (end_cyc[ch] <= k);
      if (trg) begin
        for (int c = 0; c < N_CH; c++) begin
          if (armed_m[c]) begin
            push_pulse(c, k + 1, a_site[c], a_amp[c], a_rng[c], a_ph[c], a_gp[c]);
            armed_m[c] = 1'b0;
          end
        end
      end
      if (acc) begin
        if (sm) begin
          armed_m[ch] = 1'b1; a_site[ch] = site; a_amp[ch] = amp;
          a_rng[ch] = rng; a_ph[ch] = ph; a_gp[ch] = gp;
          end_cyc[ch] = 32'h7fff_ffff;
        end else begin
          push_pulse(ch, k + 1, site, amp, rng, ph, gp);
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic mon_check(input bit en, input int ch, input int site);
    logic [3:0] ec, es;
    @(negedge clk);
    #1;
    mon_en = en; mon_chan = 2'(ch); mon_site = 2'(site);
    #1;
    ec = en ? (4'b1 << ch) : 4'b0;
    es = en ? (4'b1 << site) : 4'b0;
    check(mon_chan_sel == ec, "R9 monitor channel select", mon_chan_sel, ec);
    check(mon_site_sel == es, "R9 monitor site select", mon_site_sel, es);
  endtask

  initial begin
    for (int c = 0; c < N_CH; c++) begin
      prev_obs[c] = 0; end_cyc[c] = 0; armed_m[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({en_high, en_dac, en_ref, en_low} == 0, "R4 reset enables",
          longint'({en_high, en_dac, en_ref, en_low}), 0);
    check(busy == 0 && amp_code == 0 && range_code == 0, "R7 reset busy and codes",
          longint'({busy, amp_code, range_code}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // R2 R3 R4 R5: immediate pulse with a gap
    step(1, 0, 2, 17, 1, 3, 2, 0, 0, 0);
    idle(20);
    // R3: zero phase behaves as one cycle, zero gap skipped
    step(1, 1, 0, 31, 3, 0, 0, 0, 0, 0);
    idle(12);
    // R1: two channels overlapping on different sites
    step(1, 2, 1, 9, 2, 5, 3, 0, 0, 0);
    step(1, 3, 3, 4, 0, 2, 1, 0, 0, 0);
    idle(2);
    // R7: instruction to a busy channel is ignored
    check(busy[2] == 1'b1, "R7 busy during pulse", busy[2], 1);
    step(1, 2, 3, 20, 0, 2, 0, 0, 0, 0);
    idle(25);

    // R6: deferred arming, then trigger coinciding with a new instruction
    step(1, 0, 2, 12, 1, 2, 1, 1, 0, 0);
    step(1, 3, 3, 7, 2, 1, 0, 1, 0, 0);
    idle(3);
    check(busy == 4'b1001, "R6 armed channels busy", busy, 4'b1001);
    step(1, 1, 1, 22, 3, 3, 2, 1, 1, 0);
    idle(20);
    check(busy[1] == 1'b1, "R6 newcomer stays armed", busy[1], 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(20);
    // R10: trigger with nothing armed
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(5);
    check(busy == 0, "R10 stray trigger leaves channels idle", busy, 0);

    // R8: inhibit mid-pulse together with an instruction
    step(1, 0, 1, 30, 3, 10, 0, 0, 0, 0);
    idle(5);
    step(1, 1, 2, 5, 0, 2, 2, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    check(busy == 0, "R8 channels idle after inhibit", busy, 0);
    // R8: armed channel cleared by inhibit, later trigger fires nothing
    step(1, 2, 0, 3, 1, 2, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(5);
    check(busy == 0, "R8 arming dropped by inhibit", busy, 0);
    // recovery after inhibit
    step(1, 1, 3, 14, 2, 2, 1, 0, 0, 0);
    idle(15);

    mon_check(1'b1, 2, 3);
    mon_check(1'b1, 0, 1);
    mon_check(1'b0, 3, 2);

    for (int c = 0; c < N_CH; c++)
      check(exp_q[c].size() == 0, "R7 all predicted events seen", exp_q[c].size(), 0);
    check(busy == 0, "R7 all channels idle at end", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule